// File: doc/BRIEF.md
# Clock Source Select and Control Registers

This block is the software-facing control point for a chip's system clock. It manages two clock sources: an internal oscillator with a selectable frequency range, and a PLL. Software turns a source on, waits for its ready flag, and then writes a selector code that names the source it wants. A read-only status field shows which source actually drives the system clock. That field moves to the requested source only after the source reports ready. Until then, the previous source stays in use.

The block also holds the PLL divider and output-enable settings and three bus prescaler codes, and it drives all of them out as plain ports. The oscillators are outside the block. Each one is seen as an enable output and a ready input that answers after the oscillator's own start-up delay.

Two guards protect a running clock tree:
- The PLL settings cannot be rewritten while the PLL is enabled.
- The PLL cannot be switched off while it is the source in use.

Access is a 32-bit register bus with a byte address, a write strobe, write data and combinational read data.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset, the following values hold:
  - The oscillator enable is 1 and its range code is 6.
  - The PLL enable is 0.
  - Selector, status, prescalers and PLL settings are all 0.
  - So the control word (byte address 0x00) reads 0x00000061 while the oscillator ready input is low.
- R2: In the control word (byte address 0x00), a write sets three fields, which read back and drive the matching output ports:
  - oscillator enable at bit 0
  - range code at bits 7:4
  - PLL enable at bit 24
- R3: The oscillator ready flag sits at bit 1 of the control word and the PLL ready flag at bit 25. Each flag equals its ready input as sampled at the previous clock edge, ANDed with the current enable bit. A flag therefore reads 0 from the first cycle after its enable is written to 0.
- R4: In the configuration word (byte address 0x08), a write sets four fields, which read back and drive their ports:
  - selector at bits 1:0
  - AHB prescaler at bits 7:4
  - APB1 prescaler at bits 10:8
  - APB2 prescaler at bits 13:11

  Bits 3:2 hold the status and are ignored on write.
- R5: Status follows the selector according to the selector code:
  - Code 3 (PLL): status becomes 3 one clock after a cycle in which the PLL ready flag is set.
  - Code 0 (oscillator): status becomes 0 one clock after a cycle in which the oscillator ready flag is set.
  - Codes 1 and 2: status is left unchanged.
  - In every case, status is only ever 0 or 3.
- R6: The PLL word (byte address 0x0C) keeps only its defined fields; all other bits read 0. The defined fields are:
  - source at 1:0
  - M at 5:4
  - N at 14:8
  - P at 19:17
  - Q at 27:25
  - R at 31:29
  - output enables at 16, 24 and 28

  The kept-bit mask is 0xFF0F7F33.
- R7: A write to the PLL word while the PLL enable bit is set has no effect.
- R8: A control write that clears the PLL enable while status is 3 leaves the PLL enable set. The other fields of that write still take effect.
- R9: Addresses other than 0x00, 0x08 and 0x0C read 0, and writes to them change nothing.
- R10: The status, the prescaler codes and the stored PLL word drive their output ports at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| osc_rdy_i | input | 1 | Internal oscillator reports stable output |
| pll_rdy_i | input | 1 | PLL reports lock |
| osc_en_o | output | 1 | Internal oscillator enable |
| osc_range_o | output | 4 | Internal oscillator range code |
| pll_en_o | output | 1 | PLL enable |
| src_status_o | output | 2 | Source driving the system clock (0 oscillator, 3 PLL) |
| ahb_div_o | output | 4 | AHB prescaler code, 0 is no division |
| apb1_div_o | output | 3 | APB1 prescaler code, 0 is no division |
| apb2_div_o | output | 3 | APB2 prescaler code, 0 is no division |
| pll_cfg_o | output | 32 | Stored PLL divider and enable word |

## Verification
The assertions assume two things about the inputs:
- The ready inputs are synchronous to the register clock.
- Every bus write lasts exactly one cycle, with the address and data steady around its edge.

The stimulus drives every input on the falling edge, so all four inputs are steady at each rising edge. The ready inputs are raised and dropped only by the bench, at chosen times. This lets both orders occur: ready before the selector write, and ready after it. Ready is also kept high while its enable is cleared, which exercises the gating of the flags.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int DATA_W  = 32;
  localparam int RANGE_W = 4;
  localparam int AHB_W   = 4;
  localparam int APB_W   = 3;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 2;

  localparam int CTRL_OFS = 'h00;
  localparam int CFG_OFS  = 'h08;
  localparam int PLL_OFS  = 'h0C;

  localparam int OSC_EN_BIT  = 0;
  localparam int OSC_RDY_BIT = 1;
  localparam int RANGE_LSB   = 4;
  localparam int PLL_EN_BIT  = 24;
  localparam int PLL_RDY_BIT = 25;

  localparam int SEL_LSB  = 0;
  localparam int STAT_LSB = 2;
  localparam int AHB_LSB  = 4;
  localparam int APB1_LSB = 8;
  localparam int APB2_LSB = 11;

  localparam logic [DATA_W-1:0] PLL_KEEP_MASK = 32'hFF0F7F33;

  localparam logic [SEL_W-1:0] SRC_OSC = 2'd0;
  localparam logic [SEL_W-1:0] SRC_PLL = 2'd3;

  function automatic logic [DATA_W-1:0] pack_ctrl(
    input logic osc_en, input logic osc_rdy, input logic [RANGE_W-1:0] range,
    input logic pll_en, input logic pll_rdy);
    logic [DATA_W-1:0] w;
    w = '0;
    w[OSC_EN_BIT]  = osc_en;
    w[OSC_RDY_BIT] = osc_rdy;
    w[RANGE_LSB +: RANGE_W] = range;
    w[PLL_EN_BIT]  = pll_en;
    w[PLL_RDY_BIT] = pll_rdy;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_cfg(
    input logic [SEL_W-1:0] sel, input logic [SEL_W-1:0] stat,
    input logic [AHB_W-1:0] ahb, input logic [APB_W-1:0] apb1,
    input logic [APB_W-1:0] apb2);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEL_LSB  +: SEL_W] = sel;
    w[STAT_LSB +: SEL_W] = stat;
    w[AHB_LSB  +: AHB_W] = ahb;
    w[APB1_LSB +: APB_W] = apb1;
    w[APB2_LSB +: APB_W] = apb2;
    return w;
  endfunction

  function automatic logic [SEL_W-1:0] next_status(
    input logic [SEL_W-1:0] sel, input logic [SEL_W-1:0] cur,
    input logic osc_ok, input logic pll_ok);
    logic [SEL_W-1:0] n;
    n = cur;
    if (sel == SRC_OSC && osc_ok) n = SRC_OSC;
    if (sel == SRC_PLL && pll_ok) n = SRC_PLL;
    return n;
  endfunction
endpackage

// File: rtl/clksel_rdy_flag.sv
module clksel_rdy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rdy_in,
  output logic flag
);
  logic rdy_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_s <= 1'b0;
    else        rdy_s <= rdy_in;
  end

  assign flag = rdy_s & en;
endmodule

// File: rtl/clksel_switch.sv
module clksel_switch import clksel_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             osc_ok,
  input  logic             pll_ok,
  output logic [SEL_W-1:0] status,
  output logic             switch_evt
);
  logic [SEL_W-1:0] status_nx;

  assign status_nx  = next_status(sel, status, osc_ok, pll_ok);
  assign switch_evt = (status_nx != status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= SRC_OSC;
    else        status <= status_nx;
  end
endmodule

// File: rtl/clksel_pll_word.sv
module clksel_pll_word import clksel_pkg::*; #(
  parameter logic [DATA_W-1:0] KEEP = PLL_KEEP_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              lock,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word,
  output logic              blocked
);
  logic accept;

  assign accept  = wr & ~lock;
  assign blocked = wr & lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word <= '0;
    else if (accept) word <= wdata & KEEP;
  end
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl import clksel_pkg::*; #(
  parameter int                 ADDR_W      = 8,
  parameter logic [RANGE_W-1:0] RANGE_RESET = 4'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              osc_rdy_i,
  input  logic              pll_rdy_i,
  output logic              osc_en_o,
  output logic [RANGE_W-1:0] osc_range_o,
  output logic              pll_en_o,
  output logic [SEL_W-1:0]  src_status_o,
  output logic [AHB_W-1:0]  ahb_div_o,
  output logic [APB_W-1:0]  apb1_div_o,
  output logic [APB_W-1:0]  apb2_div_o,
  output logic [DATA_W-1:0] pll_cfg_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] A_PLL  = ADDR_W'(PLL_OFS);

  logic               osc_en_q;
  logic [RANGE_W-1:0] range_q;
  logic               pll_en_q;
  logic [SEL_W-1:0]   sel_q;
  logic [AHB_W-1:0]   ahb_q;
  logic [APB_W-1:0]   apb1_q;
  logic [APB_W-1:0]   apb2_q;
  logic [SEL_W-1:0]   status;
  logic [DATA_W-1:0]  pll_word;

  logic wr_ctrl, wr_cfg, wr_pll;
  logic pll_off_blocked, pll_cfg_blocked, switch_evt;
  logic osc_flag, pll_flag;

  logic [NUM_SRC-1:0] en_vec, rdy_vec, flag_vec;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_cfg  = bus_we && (bus_addr == A_CFG);
  assign wr_pll  = bus_we && (bus_addr == A_PLL);

  assign pll_off_blocked = wr_ctrl && !bus_wdata[PLL_EN_BIT] && pll_en_q &&
                           (status == SRC_PLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en_q <= 1'b1;
      range_q  <= RANGE_RESET;
      pll_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      osc_en_q <= bus_wdata[OSC_EN_BIT];
      range_q  <= bus_wdata[RANGE_LSB +: RANGE_W];
      pll_en_q <= bus_wdata[PLL_EN_BIT] | pll_off_blocked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SRC_OSC;
      ahb_q  <= '0;
      apb1_q <= '0;
      apb2_q <= '0;
    end else if (wr_cfg) begin
      sel_q  <= bus_wdata[SEL_LSB  +: SEL_W];
      ahb_q  <= bus_wdata[AHB_LSB  +: AHB_W];
      apb1_q <= bus_wdata[APB1_LSB +: APB_W];
      apb2_q <= bus_wdata[APB2_LSB +: APB_W];
    end
  end

  assign en_vec  = {pll_en_q, osc_en_q};
  assign rdy_vec = {pll_rdy_i, osc_rdy_i};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_rdy
    clksel_rdy_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_vec[s]),
      .rdy_in (rdy_vec[s]),
      .flag   (flag_vec[s])
    );
  end

  assign osc_flag = flag_vec[0];
  assign pll_flag = flag_vec[1];

  clksel_switch u_switch (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel_q),
    .osc_ok     (osc_flag),
    .pll_ok     (pll_flag),
    .status     (status),
    .switch_evt (switch_evt)
  );

  clksel_pll_word u_pll (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_pll),
    .lock    (pll_en_q),
    .wdata   (bus_wdata),
    .word    (pll_word),
    .blocked (pll_cfg_blocked)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)
      bus_rdata = pack_ctrl(osc_en_q, osc_flag, range_q, pll_en_q, pll_flag);
    else if (bus_addr == A_CFG)
      bus_rdata = pack_cfg(sel_q, status, ahb_q, apb1_q, apb2_q);
    else if (bus_addr == A_PLL)
      bus_rdata = pll_word;
  end

  assign osc_en_o     = osc_en_q;
  assign osc_range_o  = range_q;
  assign pll_en_o     = pll_en_q;
  assign src_status_o = status;
  assign ahb_div_o    = ahb_q;
  assign apb1_div_o   = apb1_q;
  assign apb2_div_o   = apb2_q;
  assign pll_cfg_o    = pll_word;
endmodule

// File: rtl/clksel_ctrl_chk.sv
module clksel_ctrl_chk import clksel_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_en,
  input logic              pll_en,
  input logic              osc_flag,
  input logic              pll_flag,
  input logic [SEL_W-1:0]  sel,
  input logic [SEL_W-1:0]  status,
  input logic [DATA_W-1:0] pll_word,
  input logic              pll_cfg_blocked,
  input logic              switch_evt
);
  // R3
  osc_flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !osc_flag);

  // R3
  pll_flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !pll_flag);

  // R5
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == SRC_OSC) || (status == SRC_PLL));

  // R5
  status_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_evt |=> (status == $past(sel)));

  // R5
  pll_switch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(status) && status == SRC_PLL) |-> $past(pll_flag));

  // R7
  pll_word_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_cfg_blocked |=> $stable(pll_word));

  // R7
  pll_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pll_en) |-> $stable(pll_word));

  // R8
  pll_keep_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pll_en && status == SRC_PLL) |-> pll_en);
endmodule

bind clksel_ctrl clksel_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .osc_en          (osc_en_q),
  .pll_en          (pll_en_q),
  .osc_flag        (osc_flag),
  .pll_flag        (pll_flag),
  .sel             (sel_q),
  .status          (status),
  .pll_word        (pll_word),
  .pll_cfg_blocked (pll_cfg_blocked),
  .switch_evt      (switch_evt)
);

// File: tb/clksel_ctrl_tb.sv
module clksel_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        osc_rdy_i = 1'b0;
  logic        pll_rdy_i = 1'b0;
  logic        osc_en_o, pll_en_o;
  logic [3:0]  osc_range_o, ahb_div_o;
  logic [1:0]  src_status_o;
  logic [2:0]  apb1_div_o, apb2_div_o;
  logic [31:0] pll_cfg_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  clksel_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_rdy_i(osc_rdy_i),
    .pll_rdy_i(pll_rdy_i), .osc_en_o(osc_en_o), .osc_range_o(osc_range_o),
    .pll_en_o(pll_en_o), .src_status_o(src_status_o), .ahb_div_o(ahb_div_o),
    .apb1_div_o(apb1_div_o), .apb2_div_o(apb2_div_o), .pll_cfg_o(pll_cfg_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_osc_en, m_range, m_pll_en, m_sel, m_stat, m_ahb, m_apb1, m_apb2;
  int m_osc_s, m_pll_s;
  logic [31:0] m_pll;

  task automatic model_reset();
    m_osc_en = 1; m_range = 6; m_pll_en = 0; m_sel = 0; m_stat = 0;
    m_ahb = 0; m_apb1 = 0; m_apb2 = 0; m_osc_s = 0; m_pll_s = 0; m_pll = 0;
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] v;
    v = 0;
    case (a)
      8'h00: v = m_osc_en | ((m_osc_s & m_osc_en) << 1) | (m_range << 4) |
                 (m_pll_en << 24) | ((m_pll_s & m_pll_en) << 25);
      8'h08: v = m_sel | (m_stat << 2) | (m_ahb << 4) | (m_apb1 << 8) | (m_apb2 << 11);
      8'h0C: v = m_pll;
      default: v = 0;
    endcase
    return v;
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int fo, fp;
      fo = m_osc_s & m_osc_en;
      fp = m_pll_s & m_pll_en;
      if (m_sel == 0 && fo == 1) m_stat = 0;
      else if (m_sel == 3 && fp == 1) m_stat = 3;
      if (bus_we && bus_addr == 8'h0C && m_pll_en == 0)
        m_pll = bus_wdata & 32'hFF0F7F33;
      if (bus_we && bus_addr == 8'h08) begin
        m_sel  = bus_wdata & 3;
        m_ahb  = (bus_wdata >> 4) & 15;
        m_apb1 = (bus_wdata >> 8) & 7;
        m_apb2 = (bus_wdata >> 11) & 7;
      end
      if (bus_we && bus_addr == 8'h00) begin
        m_osc_en = bus_wdata[0];
        m_range  = (bus_wdata >> 4) & 15;
        if (!(m_pll_en == 1 && m_stat_before_is_pll(fo, fp) && !bus_wdata[24]))
          m_pll_en = bus_wdata[24];
      end
      m_osc_s = osc_rdy_i;
      m_pll_s = pll_rdy_i;
    end
  end

  // status value that held before this edge's update (saved each cycle)
  int m_stat_prev = 0;
  function automatic bit m_stat_before_is_pll(input int fo, input int fp);
    return (m_stat_prev == 3);
  endfunction
  always @(negedge clk) m_stat_prev = m_stat;

  // Per-cycle comparison with the model (R10, R2, R9)
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        chk("R10 model status port", {30'd0, src_status_o}, m_stat);
        chk("R10 model ahb port", {28'd0, ahb_div_o}, m_ahb);
        chk("R10 model apb ports", {26'd0, apb2_div_o, apb1_div_o}, (m_apb2 << 3) | m_apb1);
        chk("R10 model pll port", pll_cfg_o, m_pll);
        chk("R2 model enable ports", {26'd0, osc_range_o, pll_en_o, osc_en_o},
            (m_range << 2) | (m_pll_en << 1) | m_osc_en);
        chk("R9 model read data", bus_rdata, model_read(bus_addr));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 ctrl reset", 8'h00, 32'h00000061);
    rd_chk("R1 cfg reset", 8'h08, 32'h0);
    rd_chk("R1 pll reset", 8'h0C, 32'h0);
    chk("R1 enable ports", {30'd0, pll_en_o, osc_en_o}, 32'h1);
    // R3 oscillator ready flag
    osc_rdy_i = 1'b1;
    idle(2);
    rd_chk("R3 osc ready flag", 8'h00, 32'h00000063);
    // R6 PLL word
    wr(8'h0C, 32'h00092011);
    rd_chk("R6 pll word", 8'h0C, 32'h00092011);
    // R2 PLL enable
    wr(8'h00, 32'h01000061);
    chk("R2 pll_en port", {31'd0, pll_en_o}, 32'h1);
    rd_chk("R2 ctrl with pll", 8'h00, 32'h01000063);
    // R7 locked write
    wr(8'h0C, 32'h0);
    rd_chk("R7 pll word locked", 8'h0C, 32'h00092011);
    // R5 selector before ready
    wr(8'h08, 32'h00003593);
    idle(3);
    rd_chk("R5 wait for pll ready", 8'h08, 32'h00003593);
    chk("R4 ahb port", {28'd0, ahb_div_o}, 32'h9);
    chk("R4 apb ports", {26'd0, apb2_div_o, apb1_div_o}, 32'h35);
    pll_rdy_i = 1'b1;
    idle(3);
    rd_chk("R5 switched to pll", 8'h08, 32'h0000359F);
    chk("R10 status port", {30'd0, src_status_o}, 32'h3);
    // R8 blocked disable
    wr(8'h00, 32'h00000051);
    rd_chk("R8 pll kept on", 8'h00, 32'h03000053);
    // R5 back to oscillator
    wr(8'h08, 32'h0);
    idle(2);
    rd_chk("R5 switched to osc", 8'h08, 32'h0);
    // R3 pll flag drops with enable
    wr(8'h00, 32'h00000061);
    rd_chk("R3 pll flag cleared", 8'h00, 32'h00000063);
    chk("R3 pll_en port off", {31'd0, pll_en_o}, 32'h0);
    // R6 masking
    wr(8'h0C, 32'h12345678);
    rd_chk("R6 pll word masked", 8'h0C, 32'h12045630);
    // R4 status bits not writable
    wr(8'h08, 32'h0000000C);
    rd_chk("R4 status ignores write", 8'h08, 32'h0);
    // R5 unused selector code
    wr(8'h08, 32'h00000001);
    idle(2);
    rd_chk("R5 code 1 holds status", 8'h08, 32'h00000001);
    // R9 unmapped
    wr(8'h04, 32'hFFFFFFFF);
    rd_chk("R9 unmapped read", 8'h04, 32'h0);
    rd_chk("R9 ctrl untouched", 8'h00, 32'h00000063);
    rd_chk("R9 pll untouched", 8'h0C, 32'h12045630);
    // R3 oscillator flag gated by enable
    wr(8'h00, 32'h00000060);
    rd_chk("R3 osc flag gated", 8'h00, 32'h00000060);
    chk("R2 osc_en port off", {31'd0, osc_en_o}, 32'h0);
    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule